// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a 12-bit successive-approximation converter. A convert pulse controls it. The rising edge of the pulse clears the working register and cancels any conversion in progress. The falling edge starts a new conversion. From then on the block runs a conversion clock, derived from the system clock, and tests one bit per period, most significant bit first. For each test it drives a trial code to the external DAC and reads back a single comparator bit.

Outside observers see four things:
- a busy line that is high while a conversion runs;
- a conversion clock output that toggles only while busy;
- a parallel result, given in straight binary and again with the top bit inverted for two's-complement use;
- a non-return-to-zero serial stream of the decided bits.

A short-cycle input ends a conversion early at reduced resolution. The analog parts (comparator, DAC, reference, sample-hold) lie outside the block.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, sclk_out, dac_code, result and ser_out are all 0.
- R2: A rising edge on conv_in clears dac_code to 0 and drops busy on the next clock, whatever is in progress. busy stays low for as long as conv_in stays high.
- R3: One clock after conv_in falls, busy is 1 and dac_code is 0x800, which is the top bit alone.
- R4: While busy, sclk_out is high for the first HALF_DIV system cycles of each 2*HALF_DIV-cycle period and low for the rest. It is 0 whenever busy is low. A conversion of n bits keeps busy high for exactly n+1 periods.
- R5: In the last high cycle of period k, the trial bit (bit 11-k) is kept when cmp_hi is 0 and cleared when cmp_hi is 1. The next lower bit is set as its trial at the start of period k+1.
- R6: With short_n held high, a full conversion gives the largest 12-bit code that the comparator does not report as above the input. For a comparator model of "code > target", that is the target itself.
- R7: ser_out changes only at period starts and when a conversion starts, which clears it to 0. During period k+1 it carries the bit decided in period k, so the bits come out MSB first.
- R8: If short_n is low at the end of period k, the conversion stops after k+1 bits. The bits below those are 0 in the result.
- R9: result changes only in the cycle that busy falls at the end of a completed conversion. Aborted conversions and convert pulses leave it unchanged.
- R10: result_2c always equals result with bit 11 inverted.
- R11: A convert pulse that arrives during a conversion restarts the sequence from the MSB. The restarted conversion completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_in | input | 1 | Convert pulse: rise clears, fall starts |
| cmp_hi | input | 1 | Comparator: 1 means DAC output above the analog input |
| short_n | input | 1 | Short-cycle control: low at a period end stops the conversion |
| busy | output | 1 | High while a conversion runs (result not valid) |
| sclk_out | output | 1 | Conversion clock, toggles only while busy |
| dac_code | output | 12 | Trial code for the DAC |
| result | output | 12 | Last completed result, straight/offset binary |
| result_2c | output | 12 | Result with MSB inverted |
| ser_out | output | 1 | NRZ serial bit stream, MSB first |

## Verification
Full-length conversions are run on the extreme targets 0x000 and 0xFFF, on the half-scale neighbours 0x800 and 0x7FF, and on mixed patterns. The extreme targets test the keep and reject decisions on every bit. The two half-scale neighbours differ in every bit, which catches an inverted comparator sense or a wrong order of bit trials. Short cycles of eight bits and of one bit show that the stop point matches the level of short_n, and that the lower result bits stay clear. A held convert pulse and a restart in mid-conversion separate a clearing of the working register from a change to the stored result.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } conv_edge_e;

    // Per-cycle events of the conversion clock.
    typedef struct packed {
        logic mid;   // last high cycle of a period (decision point)
        logic wrap;  // last cycle of a period (next period begins)
    } sar_tick_t;

    function automatic logic [11:0] twos_view(input logic [11:0] code);
        return {~code[11], code[10:0]};
    endfunction

endpackage

// File: rtl/sar_conv_edge.sv
module sar_conv_edge
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_in,
    output conv_edge_e edge_o
);
    logic conv_q;

    always_ff @(posedge clk) begin
        if (rst) conv_q <= 1'b0;
        else     conv_q <= conv_in;
    end

    always_comb begin
        if (conv_in && !conv_q)      edge_o = EDGE_RISE;
        else if (!conv_in && conv_q) edge_o = EDGE_FALL;
        else                         edge_o = EDGE_NONE;
    end
endmodule

// File: rtl/sar_timer.sv
module sar_timer
    import sar_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output sar_tick_t tick,
    output logic      sclk
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] PH_MID  = PW'(HALF_DIV - 1);
    localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);
    localparam logic [PW-1:0] PH_HALF = PW'(HALF_DIV);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run)          phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                       phase <= phase + 1'b1;
    end

    assign tick.mid  = run && (phase == PH_MID);
    assign tick.wrap = run && (phase == PH_LAST);
    assign sclk      = run && (phase < PH_HALF);

    // R4: a decision point is always followed by a low clock half
    p_mid_then_low_r4: assert property (@(posedge clk) disable iff (rst)
        tick.mid |=> (!sclk || !run));
endmodule

// File: rtl/sar_approx.sv
module sar_approx
    import sar_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             start,
    input  sar_tick_t        tick,
    input  logic             cmp_hi,
    input  logic             short_n,
    output logic [WIDTH-1:0] work_o,
    output logic             ser_o,
    output logic             done_o
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam int IW = $clog2(WIDTH);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [CW-1:0]    PER_TOP  = CW'(WIDTH - 1);

    logic [WIDTH-1:0] work;
    logic [CW-1:0]    per;
    logic             last;
    logic             dec;
    logic             ser;
    logic [IW-1:0]    cur_idx;
    logic [IW-1:0]    nxt_idx;

    always_comb begin
        cur_idx = IW'(WIDTH - 1 - int'(per));
        nxt_idx = (cur_idx != '0) ? cur_idx - 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work <= '0;
            per  <= '0;
            last <= 1'b0;
            dec  <= 1'b0;
            ser  <= 1'b0;
        end else if (clear) begin
            work <= '0;
            per  <= '0;
            last <= 1'b0;
        end else if (start) begin
            work <= MSB_ONLY;
            per  <= '0;
            last <= 1'b0;
            dec  <= 1'b0;
            ser  <= 1'b0;
        end else begin
            if (tick.mid && !last) begin
                work[cur_idx] <= ~cmp_hi;
                dec           <= ~cmp_hi;
            end
            if (tick.wrap && !last) begin
                ser <= dec;
                if (per == PER_TOP || !short_n) begin
                    last <= 1'b1;
                end else begin
                    work[nxt_idx] <= 1'b1;
                    per           <= per + 1'b1;
                end
            end
        end
    end

    assign work_o = work;
    assign ser_o  = ser;
    assign done_o = tick.wrap && last;

    // R7: serial output moves only at a period start or a conversion start
    p_ser_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(tick.wrap || start) |=> $stable(ser));

    // R5: a decision never adds set bits to the working code
    p_decide_r5: assert property (@(posedge clk) disable iff (rst)
        (tick.mid && !last) |=> ($countones(work) <= $countones($past(work))));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int WIDTH    = 12,
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_in,
    input  logic             cmp_hi,
    input  logic             short_n,
    output logic             busy,
    output logic             sclk_out,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] result,
    output logic [WIDTH-1:0] result_2c,
    output logic             ser_out
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    conv_edge_e       cedge;
    sar_tick_t        tick;
    logic             conv_rise;
    logic             conv_fall;
    logic             done;
    logic             busy_q;
    logic [WIDTH-1:0] work;
    logic [WIDTH-1:0] result_q;

    sar_conv_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .conv_in (conv_in),
        .edge_o  (cedge)
    );

    assign conv_rise = (cedge == EDGE_RISE);
    assign conv_fall = (cedge == EDGE_FALL);

    sar_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_q),
        .tick (tick),
        .sclk (sclk_out)
    );

    sar_approx #(.WIDTH(WIDTH)) u_approx (
        .clk     (clk),
        .rst     (rst),
        .clear   (conv_rise),
        .start   (conv_fall),
        .tick    (tick),
        .cmp_hi  (cmp_hi),
        .short_n (short_n),
        .work_o  (work),
        .ser_o   (ser_out),
        .done_o  (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            result_q <= '0;
        end else if (conv_rise) begin
            busy_q <= 1'b0;
        end else if (conv_fall) begin
            busy_q <= 1'b1;
        end else if (done) begin
            busy_q   <= 1'b0;
            result_q <= work;
        end
    end

    assign busy     = busy_q;
    assign dac_code = work;
    assign result   = result_q;

    generate
        if (WIDTH == 12) begin : g_tc12
            assign result_2c = twos_view(result_q);
        end else begin : g_tcn
            assign result_2c = {~result_q[WIDTH-1], result_q[WIDTH-2:0]};
        end
    endgenerate

    // R9: the stored result moves only on completion
    p_result_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(result_q));

    // R9: completion lands the working code and ends busy
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !conv_rise) |=> (!busy_q && result_q == $past(work)));

    // R3: a start loads the MSB trial and raises busy
    p_start_msb_r3: assert property (@(posedge clk) disable iff (rst)
        conv_fall |=> (busy_q && work == MSB_ONLY));

    // R2: a rising convert edge clears and idles
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        conv_rise |=> (work == '0 && !busy_q));
endmodule

// File: tb/sar_sequencer_bench.sv
module sar_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 12;
    localparam int H = 4;
    localparam int P = 2 * H;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         conv_in = 1'b0;
    logic         short_n = 1'b1;
    logic         cmp_hi;
    logic         busy, sclk_out, ser_out;
    logic [W-1:0] dac_code, result, result_2c;
    logic [W-1:0] target = '0;
    int           stop_bits = W;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_hi = (dac_code > target);

    sar_sequencer #(.WIDTH(W), .HALF_DIV(H)) u_sar_sequencer (
        .clk       (clk),
        .rst       (rst),
        .conv_in   (conv_in),
        .cmp_hi    (cmp_hi),
        .short_n   (short_n),
        .busy      (busy),
        .sclk_out  (sclk_out),
        .dac_code  (dac_code),
        .result    (result),
        .result_2c (result_2c),
        .ser_out   (ser_out)
    );

    // Behavioural reference model
    logic         m_conv_q = 1'b0;
    logic         m_busy = 1'b0;
    int           m_t = 0;
    int           m_nb = W;
    logic [W-1:0] m_code = '0;
    logic [W-1:0] m_res = '0;
    logic         m_ser = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_t = 0; m_nb = W; m_code = '0; m_res = '0; m_ser = 0;
            m_conv_q = 0;
        end else begin
            if (conv_in && !m_conv_q) begin
                m_busy = 0; m_code = '0;
            end else if (!conv_in && m_conv_q) begin
                m_busy = 1; m_t = 0; m_code = 12'h800; m_ser = 0; m_nb = W;
            end else if (m_busy) begin
                int ph, pr;
                ph = m_t % P;
                pr = m_t / P;
                if (ph == H - 1 && pr < m_nb) begin
                    if (m_code > target) m_code[W-1-pr] = 1'b0;
                end
                if (ph == P - 1) begin
                    if (pr == m_nb) begin
                        m_busy = 0;
                        m_res = m_code;
                    end else begin
                        m_ser = m_code[W-1-pr];
                        if (pr == W - 1 || !short_n) m_nb = pr + 1;
                        else m_code[W-2-pr] = 1'b1;
                    end
                end
                m_t++;
            end
            m_conv_q = conv_in;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison and short-cycle drive, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == m_busy, "R4 busy", busy, m_busy);
            chk(sclk_out == (m_busy && (m_t % P) < H), "R4 sclk", sclk_out,
                m_busy && (m_t % P) < H);
            chk(dac_code == m_code, "R5 dac_code", dac_code, m_code);
            chk(result == m_res, "R9 result", result, m_res);
            chk(ser_out == m_ser, "R7 ser_out", ser_out, m_ser);
            chk(result_2c == {~result[W-1], result[W-2:0]}, "R10 result_2c",
                result_2c, {~result[W-1], result[W-2:0]});
        end
        short_n = !(m_busy && ((m_t / P) + 1 >= stop_bits));
    end

    function automatic logic [W-1:0] trunc(input logic [W-1:0] v, input int nb);
        logic [W-1:0] mask;
        mask = '1;
        mask = mask << (W - nb);
        return v & mask;
    endfunction

    task automatic convert(input logic [W-1:0] tgt, input int nb, input int plen,
                           input string tag);
        logic [W-1:0] exp_v;
        logic [W-1:0] sbits;
        @(negedge clk);
        target = tgt;
        stop_bits = nb;
        conv_in = 1'b1;
        repeat (plen) @(negedge clk);
        conv_in = 1'b0;
        @(negedge clk);
        chk(busy && dac_code == 12'h800, "R3 start", dac_code, 12'h800);
        sbits = '0;
        for (int k = 1; k <= (nb + 1) * P + 1; k++) begin
            @(negedge clk);
            if (k % P == H && k / P >= 1 && k / P <= nb)
                sbits = {sbits[W-2:0], ser_out};
        end
        exp_v = trunc(tgt, nb);
        chk(!busy && result == exp_v, tag, result, exp_v);
        chk(sbits == (exp_v >> (W - nb)), "R7 serial order", sbits, exp_v >> (W - nb));
        chk(result_2c == (exp_v ^ 12'h800), "R10 twos", result_2c, exp_v ^ 12'h800);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", wd, 100000);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !sclk_out && dac_code == 0 && result == 0 && !ser_out,
            "R1 reset", {busy, sclk_out, ser_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !sclk_out && dac_code == 0 && result == 0 && !ser_out,
            "R1 after reset", dac_code, 0);

        convert(12'h000, W, 3, "R6 zero");
        convert(12'hFFF, W, 3, "R6 full scale");
        convert(12'h800, W, 2, "R6 half");
        convert(12'h7FF, W, 5, "R6 below half");
        convert(12'hA5C, W, 3, "R6 pattern");
        convert(12'h123, W, 1, "R6 pattern2");
        convert(12'hABC, 8, 3, "R8 short 8 bits");
        convert(12'hC00, 1, 3, "R8 short 1 bit");

        // R2 / R9: long held pulse clears the DAC, keeps busy low and result intact
        @(negedge clk);
        target = 12'h555;
        stop_bits = W;
        conv_in = 1'b1;
        repeat (2) @(negedge clk);
        chk(dac_code == 0 && !busy, "R2 clear", dac_code, 0);
        repeat (20) @(negedge clk);
        chk(!busy, "R2 busy low while held", busy, 0);
        chk(result == 12'h800, "R9 result held", result, 12'h800);
        conv_in = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy, "R11 running", busy, 1);
        chk(result == 12'h800, "R9 held during run", result, 12'h800);

        // R11: restart in mid-conversion
        conv_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!busy && dac_code == 0, "R11 abort", dac_code, 0);
        target = 12'h3C3;
        conv_in = 1'b0;
        @(negedge clk);
        chk(busy && dac_code == 12'h800, "R11 restart MSB", dac_code, 12'h800);
        repeat ((W + 1) * P + 1) @(negedge clk);
        chk(!busy && result == 12'h3C3, "R11 restart result", result, 12'h3C3);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule